// File: doc/BRIEF.md
# Transmit Gearbox Sequence Pacer

This block is the user-side pacing logic for a transmit gearbox that packs 64-bit payloads with a 2-bit or 3-bit sync header (64B/66B or 64B/67B framing). It keeps the sequence count that the gearbox needs. It also tells the upstream data source, through a ready strobe, when the gearbox cannot take a payload word. Two static pins select the framing and the width of the user interface. The block registers the payload word and the header before passing them on, together with the count that belongs to them.

The source side uses valid/ready flow with the valid side always asserted. The source offers a new word every cycle and must keep the same word while `src_ready` is low. In that cycle the block ignores the word and does not capture it. The header is not flow-controlled: the block captures it on every cycle. The framing and width pins may change only while `rst` is high. If they change at any other time, the behaviour is undefined.

The count advances on every clock with the 4-byte interface. With the 2-byte interface it advances on every second clock. Each framing has fixed count values at which the gearbox does not accept a payload. The block holds the source for every cycle spent at one of those values.

Top module: `gbx_pacer`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_seq`, `out_data` and `out_hdr` are all 0, `src_ready` is 1, and the 2-byte phase restarts so that the next count step happens on the second clock after reset is released.
- R2: With `cfg_enc67`=0 (66-bit framing), `out_seq` counts 0,1,…,32 and then wraps to 0. It never exceeds 32.
- R3: With `cfg_enc67`=1 (67-bit framing), `out_seq` counts 0,1,…,66 and then wraps to 0. It never exceeds 66.
- R4: With `cfg_wide`=1 (4-byte interface), the count steps once per clock. With `cfg_wide`=0 (2-byte interface), it steps once per two clocks, so each value stays on `out_seq` for exactly two cycles.
- R5: With 66-bit framing, `out_seq[6]` and `out_hdr[2]` are always 0.
- R6: With 66-bit framing, `src_ready` is low in a cycle exactly when the value `out_seq` shows in the next cycle is 31.
- R7: With 67-bit framing, `src_ready` is low in a cycle exactly when the value `out_seq` shows in the next cycle is 21, 44 or 65.
- R8: Over one full count period from reset, `src_ready` is low for 1 cycle out of 33 (66-bit, 4-byte), 2 out of 66 (66-bit, 2-byte), 3 out of 67 (67-bit, 4-byte) and 6 out of 134 (67-bit, 2-byte).
- R9: `out_data` in cycle t+1 equals `src_data` of cycle t when `src_ready` was high in cycle t. Otherwise it keeps its previous value, and the word offered during the pause has no effect.
- R10: `out_hdr` in cycle t+1 equals `src_hdr` of cycle t in every cycle, pauses included. Bit 2 is forced to 0 under 66-bit framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enc67 | input | 1 | 0: 66-bit framing, 1: 67-bit framing (static) |
| cfg_wide | input | 1 | 0: 2-byte interface, 1: 4-byte interface (static) |
| src_data | input | DATA_W | Payload word offered by the source |
| src_hdr | input | HDR_W | Sync header offered by the source |
| src_ready | output | 1 | High: the word is taken this cycle; low: the source holds the word |
| out_seq | output | SEQ_W | Sequence count sent to the gearbox |
| out_data | output | DATA_W | Registered payload word, aligned with out_seq |
| out_hdr | output | HDR_W | Registered header, aligned with out_seq |

## Verification
A corrupted count shows on `out_seq` one cycle later, as a skipped value, a repeated value or a wrong wrap point. If the 2-byte phase is lost, a count value stays on `out_seq` for one cycle or for three cycles instead of two, and the change is visible within two cycles. A wrong pause decode shows at once as a `src_ready` mismatch. One cycle later it shows as `out_data` frozen or updated in the wrong cycle. The stall count per period then differs from the expected figure.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

  // framing selection
  typedef enum logic {
    ENC_66 = 1'b0,
    ENC_67 = 1'b1
  } gbx_enc_e;

  // static configuration, sampled only as a whole
  typedef struct packed {
    gbx_enc_e enc;
    logic     wide;
  } gbx_cfg_t;

endpackage

// File: rtl/gbx_seq_counter.sv
module gbx_seq_counter
  import gbx_pkg::*;
#(
  parameter int SEQ_W  = 7,
  parameter int LAST66 = 32,
  parameter int LAST67 = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  gbx_cfg_t         cfg,
  output logic [SEQ_W-1:0] cnt
);

  localparam logic [SEQ_W-1:0] L66 = SEQ_W'(LAST66);
  localparam logic [SEQ_W-1:0] L67 = SEQ_W'(LAST67);

  logic             phase;
  logic             step;
  logic [SEQ_W-1:0] last;

  assign last = (cfg.enc == ENC_67) ? L67 : L66;
  // 4-byte steps every cycle; 2-byte steps on the second cycle of a pair
  assign step = cfg.wide | phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      phase <= cfg.wide ? 1'b0 : ~phase;
      if (step) begin
        cnt <= (cnt == last) ? '0 : cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gbx_pause_decode.sv
module gbx_pause_decode
  import gbx_pkg::*;
#(
  parameter int                       SEQ_W   = 7,
  parameter int                       N66     = 1,
  parameter logic [N66*SEQ_W-1:0]     P66     = 7'd31,
  parameter int                       N67     = 3,
  parameter logic [N67*SEQ_W-1:0]     P67     = {7'd65, 7'd44, 7'd21}
) (
  input  logic [SEQ_W-1:0] cnt,
  input  gbx_enc_e         enc,
  output logic             hold
);

  logic [N66-1:0] hit66;
  logic [N67-1:0] hit67;

  for (genvar i = 0; i < N66; i++) begin : g_p66
    assign hit66[i] = (cnt == P66[i*SEQ_W +: SEQ_W]);
  end

  for (genvar j = 0; j < N67; j++) begin : g_p67
    assign hit67[j] = (cnt == P67[j*SEQ_W +: SEQ_W]);
  end

  assign hold = (enc == ENC_67) ? (|hit67) : (|hit66);

endmodule

// File: rtl/gbx_out_stage.sv
module gbx_out_stage
  import gbx_pkg::*;
#(
  parameter int SEQ_W  = 7,
  parameter int DATA_W = 32,
  parameter int HDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  gbx_cfg_t          cfg,
  input  logic [SEQ_W-1:0]  cnt,
  input  logic              take,
  input  logic [DATA_W-1:0] src_data,
  input  logic [HDR_W-1:0]  src_hdr,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DATA_W-1:0] out_data,
  output logic [HDR_W-1:0]  out_hdr
);

  logic [SEQ_W-1:0] seq_m;
  logic [HDR_W-1:0] hdr_m;

  // 66-bit framing drives the top count bit and top header bit low
  always_comb begin
    seq_m = cnt;
    hdr_m = src_hdr;
    if (cfg.enc == ENC_66) begin
      seq_m[SEQ_W-1] = 1'b0;
      hdr_m[HDR_W-1] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_seq  <= '0;
      out_data <= '0;
      out_hdr  <= '0;
    end else begin
      out_seq <= seq_m;
      out_hdr <= hdr_m;
      if (take) begin
        out_data <= src_data;
      end
    end
  end

endmodule

// File: rtl/gbx_pacer.sv
module gbx_pacer
  import gbx_pkg::*;
#(
  parameter int                   SEQ_W  = 7,
  parameter int                   DATA_W = 32,
  parameter int                   HDR_W  = 3,
  parameter int                   LAST66 = 32,
  parameter int                   LAST67 = 66,
  parameter int                   N66    = 1,
  parameter logic [N66*SEQ_W-1:0] P66    = 7'd31,
  parameter int                   N67    = 3,
  parameter logic [N67*SEQ_W-1:0] P67    = {7'd65, 7'd44, 7'd21}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enc67,
  input  logic              cfg_wide,
  input  logic [DATA_W-1:0] src_data,
  input  logic [HDR_W-1:0]  src_hdr,
  output logic              src_ready,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [DATA_W-1:0] out_data,
  output logic [HDR_W-1:0]  out_hdr
);

  gbx_cfg_t         cfg;
  logic [SEQ_W-1:0] cnt;
  logic             hold;

  assign cfg.enc  = cfg_enc67 ? ENC_67 : ENC_66;
  assign cfg.wide = cfg_wide;

  gbx_seq_counter #(
    .SEQ_W (SEQ_W),
    .LAST66(LAST66),
    .LAST67(LAST67)
  ) u_cnt (
    .clk(clk),
    .rst(rst),
    .cfg(cfg),
    .cnt(cnt)
  );

  gbx_pause_decode #(
    .SEQ_W(SEQ_W),
    .N66  (N66),
    .P66  (P66),
    .N67  (N67),
    .P67  (P67)
  ) u_pause (
    .cnt (cnt),
    .enc (cfg.enc),
    .hold(hold)
  );

  assign src_ready = ~hold;

  gbx_out_stage #(
    .SEQ_W (SEQ_W),
    .DATA_W(DATA_W),
    .HDR_W (HDR_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .cnt     (cnt),
    .take    (src_ready),
    .src_data(src_data),
    .src_hdr (src_hdr),
    .out_seq (out_seq),
    .out_data(out_data),
    .out_hdr (out_hdr)
  );

endmodule

// File: rtl/gbx_pacer_chk.sv
module gbx_pacer_chk #(
  parameter int                   SEQ_W  = 7,
  parameter int                   DATA_W = 32,
  parameter int                   HDR_W  = 3,
  parameter int                   LAST66 = 32,
  parameter int                   LAST67 = 66,
  parameter int                   N66    = 1,
  parameter logic [N66*SEQ_W-1:0] P66    = 7'd31,
  parameter int                   N67    = 3,
  parameter logic [N67*SEQ_W-1:0] P67    = {7'd65, 7'd44, 7'd21}
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enc67,
  input logic              cfg_wide,
  input logic [DATA_W-1:0] src_data,
  input logic [HDR_W-1:0]  src_hdr,
  input logic              src_ready,
  input logic [SEQ_W-1:0]  out_seq,
  input logic [DATA_W-1:0] out_data,
  input logic [HDR_W-1:0]  out_hdr
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  function automatic logic is_pz(input logic [SEQ_W-1:0] v, input logic e67);
    logic r;
    r = 1'b0;
    if (e67) begin
      for (int i = 0; i < N67; i++) if (v == P67[i*SEQ_W +: SEQ_W]) r = 1'b1;
    end else begin
      for (int i = 0; i < N66; i++) if (v == P66[i*SEQ_W +: SEQ_W]) r = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [HDR_W-1:0] hmask(input logic [HDR_W-1:0] h, input logic e67);
    logic [HDR_W-1:0] r;
    r = h;
    if (!e67) r[HDR_W-1] = 1'b0;
    return r;
  endfunction

  // R2
  seq_wrap66_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enc67 |-> out_seq <= SEQ_W'(LAST66));

  // R3
  seq_wrap67_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_enc67 |-> out_seq <= SEQ_W'(LAST67));

  // R4
  wide_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cfg_wide && out_seq != (cfg_enc67 ? SEQ_W'(LAST67) : SEQ_W'(LAST66)))
      |=> out_seq == $past(out_seq) + 1'b1);

  // R5
  top_bits_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_enc67 |-> (!out_seq[SEQ_W-1] && !out_hdr[HDR_W-1]));

  // R6 R7
  pause_align_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> (is_pz(out_seq, cfg_enc67) == !$past(src_ready)));

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !src_ready) |=> $stable(out_data));

  // R10
  hdr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    armed |=> out_hdr == hmask($past(src_hdr), cfg_enc67));

endmodule

bind gbx_pacer gbx_pacer_chk #(
  .SEQ_W (SEQ_W),
  .DATA_W(DATA_W),
  .HDR_W (HDR_W),
  .LAST66(LAST66),
  .LAST67(LAST67),
  .N66   (N66),
  .P66   (P66),
  .N67   (N67),
  .P67   (P67)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_enc67(cfg_enc67),
  .cfg_wide (cfg_wide),
  .src_data (src_data),
  .src_hdr  (src_hdr),
  .src_ready(src_ready),
  .out_seq  (out_seq),
  .out_data (out_data),
  .out_hdr  (out_hdr)
);

// File: tb/tb_gbx_pacer.sv
module tb_gbx_pacer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enc67 = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [31:0] src_data = '0;
  logic [2:0]  src_hdr = '0;
  logic        src_ready;
  logic [6:0]  out_seq;
  logic [31:0] out_data;
  logic [2:0]  out_hdr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gbx_pacer dut (
    .clk(clk), .rst(rst), .cfg_enc67(cfg_enc67), .cfg_wide(cfg_wide),
    .src_data(src_data), .src_hdr(src_hdr), .src_ready(src_ready),
    .out_seq(out_seq), .out_data(out_data), .out_hdr(out_hdr)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_pause(input bit e67, input int v);
    if (e67) return (v == 21 || v == 44 || v == 65);
    return (v == 31);
  endfunction

  task automatic run_cfg(input bit e67, input bit w);
    int last, period, stalls, maxseq, m_cnt, e_seq, e_hdr;
    bit m_ph, exp_rdy, prev_rdy;
    logic [31:0] e_data;
    int pq[$];
    int exp_pq[$];
    string tg;
    tg = e67 ? (w ? "67B/4B" : "67B/2B") : (w ? "66B/4B" : "66B/2B");
    rst = 1'b1;
    cfg_enc67 = e67;
    cfg_wide = w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk({"R1 seq ", tg}, out_seq, 0);
    chk({"R1 data ", tg}, out_data, 0);
    chk({"R1 hdr ", tg}, out_hdr, 0);
    chk({"R1 ready ", tg}, src_ready, 1);
    last = e67 ? 66 : 32;
    period = (last + 1) * (w ? 1 : 2);
    m_cnt = 0; m_ph = 0; e_data = '0;
    stalls = 0; maxseq = 0; prev_rdy = 1;
    for (int c = 0; c < 3 * period; c++) begin
      src_data = $urandom;
      src_hdr = 3'($urandom);
      #1;
      exp_rdy = !ref_pause(e67, m_cnt);
      // R6 R7 ready against the reference schedule
      chk({e67 ? "R7 ready " : "R6 ready ", tg}, src_ready, exp_rdy);
      if (c < period && !src_ready) stalls++;
      prev_rdy = src_ready;
      @(posedge clk);
      e_seq = m_cnt;
      if (exp_rdy) e_data = src_data;
      e_hdr = e67 ? int'(src_hdr) : int'(src_hdr[1:0]);
      if (w || m_ph) m_cnt = (m_cnt == last) ? 0 : m_cnt + 1;
      m_ph = w ? 1'b0 : !m_ph;
      @(negedge clk);
      // R2 R3 R4 count sequence, wrap and rate
      chk({e67 ? "R3/R4 seq " : "R2/R4 seq ", tg}, out_seq, e_seq);
      // R9 data capture and hold
      chk({"R9 data ", tg}, out_data, e_data);
      // R10 header pass-through
      chk({"R10 hdr ", tg}, out_hdr, e_hdr);
      if (!e67) begin
        // R5 top bits forced low
        chk({"R5 seq6 ", tg}, out_seq[6], 0);
        chk({"R5 hdr2 ", tg}, out_hdr[2], 0);
      end
      if (int'(out_seq) > maxseq) maxseq = out_seq;
      if (!prev_rdy) begin
        bit seen = 0;
        foreach (pq[k]) if (pq[k] == int'(out_seq)) seen = 1;
        if (!seen) pq.push_back(int'(out_seq));
      end
    end
    // R2 R3 wrap value
    chk({e67 ? "R3 max " : "R2 max ", tg}, maxseq, last);
    // R8 stalls per period
    chk({"R8 stalls ", tg}, stalls, (e67 ? 3 : 1) * (w ? 1 : 2));
    if (e67) exp_pq = '{21, 44, 65};
    else     exp_pq = '{31};
    // R6 R7 exact pause values
    chk({e67 ? "R7 npause " : "R6 npause ", tg}, pq.size(), exp_pq.size());
    foreach (exp_pq[k]) begin
      if (k < pq.size()) chk({e67 ? "R7 pval " : "R6 pval ", tg}, pq[k], exp_pq[k]);
    end
  endtask

  initial begin
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b1, 1'b1);
    run_cfg(1'b1, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule